// File: doc/BRIEF.md
# Prefetching Page Buffer Set

This block sits between a word-wide read port and a slow memory array that delivers a whole 128-bit page per access. It keeps four page buffers. Each buffer has a valid bit and a page tag. Every read is compared against all of them.

- On a hit, the selected 32-bit word comes back in the cycle after the request is accepted, with no wait states.
- On a miss, the block issues one page read to the array. It forwards the requested word from the returning page in the same cycle that it stores the page, so the requester does not wait for a second lookup.

After a demand fill the block can fetch the next sequential page speculatively.

- The speculative page lands in the least-recently-used buffer and keeps that rank, so an unused prefetch is the first page to be evicted.
- A demand fill goes into the least-recently-used buffer and becomes most-recently-used at once.
- A hit promotes its buffer to most-recently-used, and the buffers that were more recent each move down one rank.
- A read that arrives while a prefetch is outstanding is held until the prefetch lands. It is then looked up again, so a read of the prefetched page becomes a hit and promotes that buffer.

The read address is a word address. Its two low bits select the word within the page, and the remaining bits form the page tag.

Top module: `pgbuf_set`

## Requirements
- R1: Reset clears every buffer's valid bit and leaves the block idle: `req_ready`=1, `rsp_valid`=0, `arr_req`=0. The first read of any page after reset is a miss. No two valid buffers ever hold the same page tag.
- R2: A read whose page tag matches a valid buffer, accepted while the block is idle, returns `rsp_valid`=1 and `rsp_hit`=1 in the next cycle. `rsp_data` is word `req_addr[1:0]` of that page, where word w occupies page bits [32w+31:32w].
- R3: A miss drives `arr_req` high for exactly one cycle, with `arr_page` = `req_addr[21:2]`. In the cycle after `arr_rvalid`, the block gives `rsp_valid`=1 and `rsp_hit`=0, with the requested word taken from `arr_rdata`. The page is kept for later hits.
- R4: A demand fill replaces the least-recently-used buffer and makes that buffer most-recently-used.
- R5: A hit makes its buffer most-recently-used. Every buffer that was more recent than it drops one rank, and the other buffers keep their ranks.
- R6: When `pf_en`=1 as a demand fill completes, the block requests page tag+1 (wrapping at the tag width) in the following cycle. That page is written into the least-recently-used buffer without changing any rank.
- R7: No prefetch is issued when `pf_en`=0, or when the next page is already valid in a buffer other than the one the demand fill replaces.
- R8: A read accepted while a prefetch is outstanding waits until the prefetch lands and is then looked up. If it targets the prefetched page, it completes with `rsp_hit`=1 and promotes that buffer.
- R9: A one-cycle `flush` pulse clears all valid bits, so the next read of any previously buffered page is a miss.
- R10: `req_ready` is 0 while a demand fill is outstanding and while a held read is being looked up again. During a prefetch the block accepts exactly one read and then drops `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all buffers |
| pf_en | input | 1 | Enable speculative next-page prefetch |
| req_valid | input | 1 | Read request present |
| req_addr | input | 22 | Word address of the read |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| rsp_valid | output | 1 | Read data valid |
| rsp_hit | output | 1 | Read was served from a buffer |
| rsp_data | output | 32 | Read data word |
| arr_req | output | 1 | One-cycle page read request to the array |
| arr_page | output | 20 | Page tag of the array read |
| arr_rvalid | input | 1 | Array page data valid |
| arr_rdata | input | 128 | Array page data |

## Verification
Two functions can coincide in one cycle:

- A prefetch landing and a new read being accepted. The bench provokes this by issuing a read with no gap right after a prefetching miss returns, so that the read is accepted while the speculative page is still in flight.
- A demand fill's forwarded word and the issue of the following prefetch.

The bench judges the first case by requiring a hit response with correct data that took longer than one cycle. The second case is judged from the array-request count after a quiet interval. Further checks follow a replay into a later eviction order predicted by a bench-side recency model. Random page sequences with random gaps mix both collisions with ordinary hits.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_WORDS  = 4;
    localparam int unsigned DEF_NBUF   = 4;
    localparam int unsigned DEF_ADDR_W = 22;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DEMAND   = 2'd1,
        ST_PREFETCH = 2'd2,
        ST_REPLAY   = 2'd3
    } ctrl_state_e;

    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_DEMAND = 2'd1,
        FILL_SPEC   = 2'd2
    } fill_kind_e;

    typedef struct packed {
        logic       en;
        fill_kind_e kind;
    } fill_cmd_t;

endpackage

// File: rtl/pgbuf_tags.sv
module pgbuf_tags
    import pgbuf_pkg::*;
#(
    parameter int unsigned NBUF   = DEF_NBUF,
    parameter int unsigned TAG_W  = 20,
    parameter int unsigned PAGE_W = 128,
    localparam int unsigned IDX_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [IDX_W-1:0]  look_idx,
    output logic [PAGE_W-1:0] look_page,
    input  logic [TAG_W-1:0]  nxt_tag,
    input  logic [IDX_W-1:0]  skip_idx,
    output logic              nxt_present,
    input  fill_cmd_t         fill,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PAGE_W-1:0] wr_page
);

    logic [NBUF-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [NBUF];
    logic [PAGE_W-1:0] page_q [NBUF];
    logic [NBUF-1:0]   hit_vec;
    logic [NBUF-1:0]   nxt_vec;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBUF; i++) begin
            if (rst || flush) begin
                valid_q[i] <= 1'b0;
            end else if (fill.en && wr_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b1;
            end
            if (fill.en && wr_idx == IDX_W'(i)) begin
                tag_q[i]  <= wr_tag;
                page_q[i] <= wr_page;
            end
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == look_tag);
        assign nxt_vec[g] = valid_q[g] && (tag_q[g] == nxt_tag) && (skip_idx != IDX_W'(g));
    end

    always_comb begin
        look_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (hit_vec[i]) look_idx = IDX_W'(i);
        end
    end

    assign look_hit    = |hit_vec;
    assign look_page   = page_q[look_idx];
    assign nxt_present = |nxt_vec;

    // R9: an invalidate leaves no buffer valid
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R1: a page is never held twice
    assert_unique_tag_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/pgbuf_lru.sv
module pgbuf_lru
    import pgbuf_pkg::*;
#(
    parameter int unsigned NBUF = DEF_NBUF,
    localparam int unsigned IDX_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  fill_cmd_t        fill,
    output logic [IDX_W-1:0] lru_idx
);

    logic [IDX_W-1:0] rank_q [NBUF];
    logic             prom_en;
    logic [IDX_W-1:0] prom_idx;
    logic [NBUF-1:0]  seen;

    assign prom_en  = hit_en || (fill.en && fill.kind == FILL_DEMAND);
    assign prom_idx = hit_en ? hit_idx : lru_idx;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBUF; i++) begin
            if (rst) begin
                rank_q[i] <= IDX_W'(i);
            end else if (prom_en) begin
                if (IDX_W'(i) == prom_idx) begin
                    rank_q[i] <= '0;
                end else if (rank_q[i] < rank_q[prom_idx]) begin
                    rank_q[i] <= rank_q[i] + IDX_W'(1);
                end
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (rank_q[i] == IDX_W'(NBUF - 1)) lru_idx = IDX_W'(i);
        end
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < NBUF; i++) begin
            seen[rank_q[i]] = 1'b1;
        end
    end

    // R5: ranks always form a permutation
    assert_rank_perm_R5: assert property (@(posedge clk) disable iff (rst)
        seen == '1);

    // R6: a speculative install or an idle cycle leaves the eviction choice alone
    assert_spec_stays_lru_R6: assert property (@(posedge clk) disable iff (rst)
        !prom_en |=> $stable(lru_idx));

endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int unsigned NBUF   = DEF_NBUF,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned WORDS  = DEF_WORDS,
    localparam int unsigned IDX_W  = $clog2(NBUF),
    localparam int unsigned WSEL_W = $clog2(WORDS),
    localparam int unsigned TAG_W  = ADDR_W - WSEL_W,
    localparam int unsigned PAGE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pf_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WORD_W-1:0] rsp_data,
    output logic              arr_req,
    output logic [TAG_W-1:0]  arr_page,
    input  logic              arr_rvalid,
    input  logic [PAGE_W-1:0] arr_rdata,
    output logic [TAG_W-1:0]  look_tag,
    input  logic              look_hit,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [PAGE_W-1:0] look_page,
    output logic [TAG_W-1:0]  nxt_tag,
    input  logic              nxt_present,
    input  logic [IDX_W-1:0]  lru_idx,
    output fill_cmd_t         fill,
    output logic              hit_en,
    output logic [IDX_W-1:0]  hit_idx
);

    ctrl_state_e       st_q, st_n;
    logic              arr_req_q, arr_req_n;
    logic [TAG_W-1:0]  arr_page_q, arr_page_n;
    logic [ADDR_W-1:0] cur_q, cur_n;
    logic              pend_q, pend_n;
    logic              rspv_q, rspv_n;
    logic              rsph_q, rsph_n;
    logic [WORD_W-1:0] rspd_q, rspd_n;

    function automatic logic [WORD_W-1:0] pick(input logic [PAGE_W-1:0] pg,
                                               input logic [WSEL_W-1:0] w);
        return pg[int'(w) * WORD_W +: WORD_W];
    endfunction

    assign req_ready = (st_q == ST_IDLE) || (st_q == ST_PREFETCH && !pend_q);
    assign look_tag  = (st_q == ST_REPLAY) ? cur_q[ADDR_W-1:WSEL_W] : req_addr[ADDR_W-1:WSEL_W];
    assign nxt_tag   = arr_page_q + TAG_W'(1);
    assign hit_idx   = look_idx;

    always_comb begin
        st_n       = st_q;
        arr_req_n  = 1'b0;
        arr_page_n = arr_page_q;
        cur_n      = cur_q;
        pend_n     = pend_q;
        rspv_n     = 1'b0;
        rsph_n     = 1'b0;
        rspd_n     = rspd_q;
        fill       = '{en: 1'b0, kind: FILL_NONE};
        hit_en     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (look_hit) begin
                        rspv_n = 1'b1;
                        rsph_n = 1'b1;
                        rspd_n = pick(look_page, req_addr[WSEL_W-1:0]);
                        hit_en = 1'b1;
                    end else begin
                        arr_req_n  = 1'b1;
                        arr_page_n = req_addr[ADDR_W-1:WSEL_W];
                        cur_n      = req_addr;
                        st_n       = ST_DEMAND;
                    end
                end
            end
            ST_DEMAND: begin
                if (arr_rvalid) begin
                    fill   = '{en: 1'b1, kind: FILL_DEMAND};
                    rspv_n = 1'b1;
                    rspd_n = pick(arr_rdata, cur_q[WSEL_W-1:0]);
                    if (pf_en && !nxt_present) begin
                        arr_req_n  = 1'b1;
                        arr_page_n = nxt_tag;
                        st_n       = ST_PREFETCH;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_PREFETCH: begin
                if (req_valid && !pend_q) begin
                    pend_n = 1'b1;
                    cur_n  = req_addr;
                end
                if (arr_rvalid) begin
                    fill = '{en: 1'b1, kind: FILL_SPEC};
                    st_n = (pend_q || req_valid) ? ST_REPLAY : ST_IDLE;
                end
            end
            ST_REPLAY: begin
                pend_n = 1'b0;
                if (look_hit) begin
                    rspv_n = 1'b1;
                    rsph_n = 1'b1;
                    rspd_n = pick(look_page, cur_q[WSEL_W-1:0]);
                    hit_en = 1'b1;
                    st_n   = ST_IDLE;
                end else begin
                    arr_req_n  = 1'b1;
                    arr_page_n = cur_q[ADDR_W-1:WSEL_W];
                    st_n       = ST_DEMAND;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            arr_req_q  <= 1'b0;
            arr_page_q <= '0;
            cur_q      <= '0;
            pend_q     <= 1'b0;
            rspv_q     <= 1'b0;
            rsph_q     <= 1'b0;
            rspd_q     <= '0;
        end else begin
            st_q       <= st_n;
            arr_req_q  <= arr_req_n;
            arr_page_q <= arr_page_n;
            cur_q      <= cur_n;
            pend_q     <= pend_n;
            rspv_q     <= rspv_n;
            rsph_q     <= rsph_n;
            rspd_q     <= rspd_n;
        end
    end

    assign rsp_valid = rspv_q;
    assign rsp_hit   = rsph_q;
    assign rsp_data  = rspd_q;
    assign arr_req   = arr_req_q;
    assign arr_page  = arr_page_q;

    // R2: a hit taken while idle answers in the very next cycle
    assert_hit_zero_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && req_valid && look_hit) |=> (rsp_valid && rsp_hit));

    // R3: returning page data is forwarded as a miss response
    assert_fill_forward_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DEMAND && arr_rvalid) |=> (rsp_valid && !rsp_hit));

    // R3: array requests are single-cycle pulses
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        arr_req |=> !arr_req);

    // R10: no acceptance during a demand fill or a replay lookup
    assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DEMAND || st_q == ST_REPLAY) |-> !req_ready);

    // R8: a read held over a prefetch is looked up once it lands
    assert_replay_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PREFETCH && arr_rvalid && (pend_q || req_valid)) |=> (st_q == ST_REPLAY));

endmodule

// File: rtl/pgbuf_set.sv
module pgbuf_set
    import pgbuf_pkg::*;
#(
    parameter int unsigned NBUF   = DEF_NBUF,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned WORDS  = DEF_WORDS,
    localparam int unsigned IDX_W  = $clog2(NBUF),
    localparam int unsigned WSEL_W = $clog2(WORDS),
    localparam int unsigned TAG_W  = ADDR_W - WSEL_W,
    localparam int unsigned PAGE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              pf_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WORD_W-1:0] rsp_data,
    output logic              arr_req,
    output logic [TAG_W-1:0]  arr_page,
    input  logic              arr_rvalid,
    input  logic [PAGE_W-1:0] arr_rdata
);

    logic [TAG_W-1:0]  look_tag;
    logic              look_hit;
    logic [IDX_W-1:0]  look_idx;
    logic [PAGE_W-1:0] look_page;
    logic [TAG_W-1:0]  nxt_tag;
    logic              nxt_present;
    logic [IDX_W-1:0]  lru_idx;
    fill_cmd_t         fill;
    logic              hit_en;
    logic [IDX_W-1:0]  hit_idx;

    pgbuf_ctrl #(
        .NBUF(NBUF), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)
    ) u_ctrl (
        .clk(clk), .rst(rst), .pf_en(pf_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .arr_req(arr_req), .arr_page(arr_page),
        .arr_rvalid(arr_rvalid), .arr_rdata(arr_rdata),
        .look_tag(look_tag), .look_hit(look_hit), .look_idx(look_idx),
        .look_page(look_page), .nxt_tag(nxt_tag), .nxt_present(nxt_present),
        .lru_idx(lru_idx), .fill(fill), .hit_en(hit_en), .hit_idx(hit_idx)
    );

    pgbuf_tags #(
        .NBUF(NBUF), .TAG_W(TAG_W), .PAGE_W(PAGE_W)
    ) u_tags (
        .clk(clk), .rst(rst), .flush(flush),
        .look_tag(look_tag), .look_hit(look_hit), .look_idx(look_idx),
        .look_page(look_page), .nxt_tag(nxt_tag), .skip_idx(lru_idx),
        .nxt_present(nxt_present), .fill(fill), .wr_idx(lru_idx),
        .wr_tag(arr_page), .wr_page(arr_rdata)
    );

    pgbuf_lru #(
        .NBUF(NBUF)
    ) u_lru (
        .clk(clk), .rst(rst), .hit_en(hit_en), .hit_idx(hit_idx),
        .fill(fill), .lru_idx(lru_idx)
    );

endmodule

// File: tb/pgbuf_set_tb.sv
module pgbuf_set_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic         clk = 1'b0;
    logic         rst, flush, pf_en, req_valid;
    logic [21:0]  req_addr;
    logic         req_ready, rsp_valid, rsp_hit;
    logic [31:0]  rsp_data;
    logic         arr_req;
    logic [19:0]  arr_page;
    logic         arr_rvalid;
    logic [127:0] arr_rdata;

    int n_chk = 0, n_fail = 0;
    int arr_cnt = 0;
    int cnt = 0;
    logic [19:0] pend_pg;
    bit done = 0;

    pgbuf_set dut_i (
        .clk(clk), .rst(rst), .flush(flush), .pf_en(pf_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .arr_req(arr_req), .arr_page(arr_page),
        .arr_rvalid(arr_rvalid), .arr_rdata(arr_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] page_word(input logic [19:0] pg, input int w);
        return (32'(pg) * 32'h9E3779B1) ^ (32'(w) * 32'h01010101) ^ 32'hC3A50000;
    endfunction

    function automatic logic [127:0] page_data(input logic [19:0] pg);
        logic [127:0] d;
        for (int w = 0; w < 4; w++) d[w*32 +: 32] = page_word(pg, w);
        return d;
    endfunction

    // slow array model: fixed latency, one page per request
    always @(posedge clk) begin
        if (rst) begin
            arr_rvalid <= 1'b0;
            arr_rdata  <= '0;
            cnt        <= 0;
        end else begin
            arr_rvalid <= 1'b0;
            if (cnt > 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    arr_rvalid <= 1'b1;
                    arr_rdata  <= page_data(pend_pg);
                end
            end
            if (arr_req) begin
                cnt     <= LAT;
                pend_pg <= arr_page;
                arr_cnt <= arr_cnt + 1;
            end
        end
    end

    // recency model of the four buffers, rank 0 = most recent
    logic [19:0] m_tag [4];
    bit          m_val [4];
    int          m_rank[4];
    int          m_reqs;
    bit          m_pf_last;

    function automatic int m_find(input logic [19:0] t, input int skip);
        for (int i = 0; i < 4; i++) if (m_val[i] && m_tag[i] == t && i != skip) return i;
        return -1;
    endfunction

    function automatic int m_lru();
        for (int i = 0; i < 4; i++) if (m_rank[i] == 3) return i;
        return 0;
    endfunction

    task automatic m_promote(input int k);
        for (int i = 0; i < 4; i++) if (i != k && m_rank[i] < m_rank[k]) m_rank[i]++;
        m_rank[k] = 0;
    endtask

    task automatic m_reset();
        for (int i = 0; i < 4; i++) begin
            m_val[i] = 0; m_rank[i] = i; m_tag[i] = '0;
        end
        m_reqs = 0; m_pf_last = 0;
    endtask

    task automatic m_access(input logic [19:0] t, input bit pfen, output bit hit);
        int k, v, v2;
        bit np;
        logic [19:0] nt;
        m_pf_last = 0;
        k = m_find(t, -1);
        if (k >= 0) begin
            hit = 1; m_promote(k);
        end else begin
            hit = 0;
            v = m_lru();
            nt = t + 20'd1;
            np = (m_find(nt, v) >= 0);
            m_tag[v] = t; m_val[v] = 1; m_promote(v); m_reqs++;
            if (pfen && !np) begin
                v2 = m_lru();
                m_tag[v2] = nt; m_val[v2] = 1; m_reqs++; m_pf_last = 1;
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [19:0] pg, input int w, input int gap,
                           input bit pfen, input string req, input bit exp_wait);
        bit eh, busy_before;
        int lat;
        repeat (gap) @(negedge clk);
        if (gap >= 8) chk(arr_cnt == m_reqs, "R7", "array request count", arr_cnt, m_reqs);
        busy_before = m_pf_last && (gap < 8);
        pf_en = pfen;
        m_access(pg, pfen, eh);
        req_valid = 1'b1;
        req_addr  = {pg, 2'(w)};
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (!rsp_valid) chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
        while (!rsp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk(rsp_valid, req, "response present", rsp_valid, 1);
        chk(rsp_hit == eh, req, "hit flag", rsp_hit, eh);
        chk(rsp_data == page_word(pg, w), req, "read data", rsp_data, page_word(pg, w));
        if (eh && !busy_before) chk(lat == 1, "R2", "hit latency", lat, 1);
        if (exp_wait) chk(lat > 1, "R8", "held behind prefetch", lat, 2);
    endtask

    task automatic do_flush();
        repeat (10) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 4; i++) m_val[i] = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; flush = 1'b0; pf_en = 1'b0; req_valid = 1'b0; req_addr = '0;
        m_reset();
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
        chk(arr_req == 1'b0, "R1", "reset arr_req", arr_req, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 cold miss, R3 forward, R2 hit on another word
        do_read(20'h00040, 0, 1, 0, "R1", 0);
        do_read(20'h00040, 3, 2, 0, "R2", 0);

        // R6 prefetch then R8 read of the prefetched page while in flight
        do_read(20'h00200, 1, 10, 1, "R3", 0);
        do_read(20'h00201, 3, 0, 1, "R8", 1);
        do_read(20'h00201, 0, 10, 0, "R5", 0);

        // R4/R5 replacement order
        do_read(20'h00300, 0, 10, 0, "R4", 0);
        do_read(20'h00301, 1, 2, 0, "R4", 0);
        do_read(20'h00302, 2, 2, 0, "R4", 0);
        do_read(20'h00303, 3, 2, 0, "R4", 0);
        do_read(20'h00300, 1, 2, 0, "R5", 0);
        do_read(20'h00310, 0, 2, 0, "R4", 0);
        do_read(20'h00300, 2, 2, 0, "R5", 0);
        do_read(20'h00301, 0, 2, 0, "R4", 0);

        // R6 unused prefetch stays least recent and is evicted first
        do_read(20'h00400, 0, 10, 1, "R6", 0);
        do_read(20'h00500, 0, 10, 0, "R6", 0);
        do_read(20'h00401, 1, 10, 0, "R6", 0);

        // R7 suppression when next page is buffered
        do_read(20'h00601, 0, 10, 0, "R7", 0);
        do_read(20'h00600, 2, 10, 1, "R7", 0);
        do_read(20'h00601, 3, 10, 0, "R7", 0);

        // R6 wrap of the next-page tag
        do_read(20'hFFFFF, 1, 10, 1, "R6", 0);
        do_read(20'h00000, 2, 10, 0, "R6", 0);

        // R9 invalidate
        do_flush();
        do_read(20'h00601, 1, 2, 0, "R9", 0);
        do_read(20'h00000, 0, 10, 0, "R9", 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [19:0] pg;
            int g;
            if ($urandom_range(0, 39) == 0) do_flush();
            pg = 20'h00700 + 20'($urandom_range(0, 9));
            g  = $urandom_range(0, 10);
            do_read(pg, $urandom_range(0, 3), g, 1'($urandom_range(0, 1)), "R5", 0);
        end
        repeat (10) @(negedge clk);
        chk(arr_cnt == m_reqs, "R7", "final array request count", arr_cnt, m_reqs);

        done = 1;
        summary();
        $finish;
    end

endmodule